// File: doc/BRIEF.md
# Outstanding Memory Request Tracker

The tracker sits between a processor's load/store request port and a cache controller. It holds every memory request that has been issued but not yet completed. Read-class requests and write-class requests are held in two separate, fully associative tables. Each table is searched by cache-line address. A new request is tested against a cap on the total number outstanding and against both tables. It is then issued, refused as full, or refused as aliased, because another request to the same line is still in flight.

Completion responses from the cache controller name a line and say which table it belongs to. The matching entry is retired. A completion that matches nothing sets a sticky error flag. Each entry carries the timestamp of its acceptance. While anything is outstanding, a watchdog looks at all entries once every threshold interval. It raises a sticky deadlock flag if any entry has grown that old. Four counters record how often each kind of alias refusal occurs.

The request port is valid/ready. `req_ready` is low during reset and high in every cycle after it. The design never stalls a sender. A request is consumed in any cycle where `req_valid` and `req_ready` are both high. `req_status` is valid in that same cycle, as a combinational function of the request and of the table state at the start of the cycle. A refused request (aliased or full) is dropped, and the sender must present it again later. The completion port has no back-pressure: each cycle with `cpl_valid` high is one completion.

Top module: `ort_tracker`

## Requirements
- R1: While reset is high, and after reset is released, `out_count` is 0, both error flags are 0 and all four alias counters are 0. `req_ready` is 0 during reset and 1 from the first clock edge after reset is released.
- R2: Request codes 0 (load) and 1 (instruction fetch) are read-class. Codes 2 to 9 are write-class: store, RMW read, RMW write, load-linked, store-conditional, locked RMW read, locked RMW write and flush. Any other code is also write-class.
- R3: `req_status` is 0 for issued, 1 for aliased and 2 for full. The status is full when `out_count` is already at or above MAX_OUT, or when the target table has no free entry. Full takes priority over aliased.
- R4: Two requests alias when their addresses match above the low OFF_W offset bits. A request that is not full is aliased if its line is held in either table, whatever its class. Otherwise it is issued into the table of its class.
- R5: An aliased or full request changes neither table nor `out_count`.
- R6: Each accepted aliased request adds one to exactly one counter. A write-class request that hits the read table counts in `n_st_on_ld`, and one that hits the write table counts in `n_st_on_st`. A read-class request that hits the write table counts in `n_ld_on_st`, and one that hits the read table counts in `n_ld_on_ld`. A full refusal counts nowhere.
- R7: A completion retires the entry for `cpl_addr`'s line in the write table when `cpl_write` is 1, or in the read table when it is 0. `out_count` drops by one, and a later request to that line is issued.
- R8: A completion whose line is not in the selected table sets `err_orphan`. The flag stays set until reset, and `out_count` is unchanged.
- R9: A request and a completion in the same cycle both take effect. The request is checked against the tables as they were before the completion, so a request to the line being retired in that cycle is aliased.
- R10: `out_count` always equals the read-table occupancy plus the write-table occupancy, and never exceeds MAX_OUT.
- R11: The watchdog arms at the edge where the outstanding count becomes nonzero. It then checks every THRESH cycles. At a check, any entry aged THRESH or more sets the sticky `err_deadlock`. Age is counted in clock edges since the entry's acceptance edge. A lone entry accepted while idle and never retired raises the flag exactly THRESH edges after its acceptance edge.
- R12: The watchdog disarms whenever the count returns to 0, and its check phase restarts at the next arming. Entries retired before they reach THRESH cycles of age never raise `err_deadlock`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be consumed this cycle |
| req_addr | input | ADDR_W | Request byte address |
| req_kind | input | 4 | Request code, see R2 |
| req_status | output | 2 | Outcome of the presented request, see R3 |
| cpl_valid | input | 1 | Completion present |
| cpl_addr | input | ADDR_W | Completed address, offset bits ignored |
| cpl_write | input | 1 | 1 selects the write table, 0 the read table |
| out_count | output | $clog2(MAX_OUT+1) | Requests outstanding |
| n_st_on_ld | output | CNT_W | Write-class refused by a read entry |
| n_st_on_st | output | CNT_W | Write-class refused by a write entry |
| n_ld_on_st | output | CNT_W | Read-class refused by a write entry |
| n_ld_on_ld | output | CNT_W | Read-class refused by a read entry |
| err_deadlock | output | 1 | Sticky: an entry reached the age threshold |
| err_orphan | output | 1 | Sticky: completion for a line not outstanding |

## Verification
The assertions take two things for granted. The inputs carry known values from the first clock on, and `cpl_valid` stays low while reset is high, so that the count-step property sees no retirement during reset. Beyond that they assume nothing about traffic: orphan completions, refused requests and same-cycle request/completion pairs are all legal. The stimulus drives every input from reset, holds the completion port idle during reset, and changes inputs only on falling edges. Every sweep pass starts from a fresh reset, so the watchdog never runs long enough to fire except in the tests aimed at it.

// File: rtl/ort_pkg.sv
package ort_pkg;

  typedef enum logic [1:0] {
    ST_ISSUED  = 2'd0,
    ST_ALIASED = 2'd1,
    ST_FULL    = 2'd2
  } req_status_e;

  localparam logic [3:0] KIND_LOAD   = 4'd0;
  localparam logic [3:0] KIND_IFETCH = 4'd1;

  // Only plain loads and instruction fetches occupy the read table.
  function automatic logic is_write_kind(input logic [3:0] kind);
    return !((kind == KIND_LOAD) || (kind == KIND_IFETCH));
  endfunction

endpackage

// File: rtl/ort_line_table.sv
module ort_line_table #(
  parameter int ENTRIES = 8,
  parameter int LINE_W  = 26,
  parameter int TIME_W  = 12,
  parameter int THRESH  = 1024,
  localparam int IW     = $clog2(ENTRIES),
  localparam int OCC_W  = $clog2(ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINE_W-1:0] lu_line,
  output logic              lu_hit,
  output logic              has_free,
  input  logic              ins_en,
  input  logic [TIME_W-1:0] now,
  input  logic              rm_en,
  input  logic [LINE_W-1:0] rm_line,
  output logic              rm_hit,
  output logic              aged_any,
  output logic [OCC_W-1:0]  occ
);

  logic [ENTRIES-1:0] vld;
  logic [ENTRIES-1:0] lu_m;
  logic [ENTRIES-1:0] rm_m;
  logic [ENTRIES-1:0] old;
  logic [IW-1:0]      free_idx;

  // Lowest-numbered empty slot receives the next insertion.
  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld[i]) free_idx = IW'(i);
    end
  end

  always_comb begin
    occ = '0;
    for (int i = 0; i < ENTRIES; i++) occ = occ + OCC_W'(vld[i]);
  end

  assign has_free = ~&vld;
  assign lu_hit   = |lu_m;
  assign rm_hit   = |rm_m;
  assign aged_any = |old;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic              v;
    logic [LINE_W-1:0] line_q;
    logic [TIME_W-1:0] stamp_q;
    logic [TIME_W-1:0] age;
    logic              take;

    assign take    = ins_en && (free_idx == IW'(g));
    assign vld[g]  = v;
    assign lu_m[g] = v && (line_q == lu_line);
    assign rm_m[g] = v && (line_q == rm_line);
    assign age     = now - stamp_q;
    assign old[g]  = v && (age >= TIME_W'(THRESH));

    always_ff @(posedge clk) begin
      if (rst)                  v <= 1'b0;
      else if (take)            v <= 1'b1;
      else if (rm_en && rm_m[g]) v <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (take) begin
        line_q  <= lu_line;
        stamp_q <= now;
      end
    end
  end

endmodule

// File: rtl/ort_watchdog.sv
module ort_watchdog #(
  parameter int THRESH = 1024,
  parameter int TIME_W = 12,
  localparam int TW    = $clog2(THRESH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy_nxt,
  input  logic              aged_any,
  output logic [TIME_W-1:0] now,
  output logic              err
);

  logic          armed_q;
  logic [TW-1:0] tmr_q;
  logic          check;

  assign check = armed_q && (tmr_q == TW'(THRESH - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      now     <= '0;
      armed_q <= 1'b0;
      tmr_q   <= '0;
      err     <= 1'b0;
    end else begin
      now     <= now + 1'b1;
      armed_q <= busy_nxt;
      if (!armed_q || check) tmr_q <= '0;
      else                   tmr_q <= tmr_q + 1'b1;
      if (check && aged_any) err <= 1'b1;
    end
  end

endmodule

// File: rtl/ort_alias_stats.sv
module ort_alias_stats #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_en,
  input  logic             req_wr,
  input  logic             cross_hit,
  output logic [CNT_W-1:0] n_st_on_ld,
  output logic [CNT_W-1:0] n_st_on_st,
  output logic [CNT_W-1:0] n_ld_on_st,
  output logic [CNT_W-1:0] n_ld_on_ld
);

  // sel: 3 store-on-load, 2 store-on-store, 1 load-on-store, 0 load-on-load
  logic [1:0] sel;
  assign sel = {req_wr, cross_hit};

  for (genvar g = 0; g < 4; g++) begin : g_cnt
    logic [CNT_W-1:0] c;
    always_ff @(posedge clk) begin
      if (rst)                           c <= '0;
      else if (hit_en && sel == 2'(g))   c <= c + 1'b1;
    end
  end

  assign n_st_on_ld = g_cnt[3].c;
  assign n_st_on_st = g_cnt[2].c;
  assign n_ld_on_st = g_cnt[1].c;
  assign n_ld_on_ld = g_cnt[0].c;

endmodule

// File: rtl/ort_tracker.sv
module ort_tracker
  import ort_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 6,
  parameter int ENTRIES = 8,
  parameter int MAX_OUT = 12,
  parameter int THRESH  = 1024,
  parameter int CNT_W   = 16,
  localparam int CW     = $clog2(MAX_OUT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_kind,
  output logic [1:0]        req_status,
  input  logic              cpl_valid,
  input  logic [ADDR_W-1:0] cpl_addr,
  input  logic              cpl_write,
  output logic [CW-1:0]     out_count,
  output logic [CNT_W-1:0]  n_st_on_ld,
  output logic [CNT_W-1:0]  n_st_on_st,
  output logic [CNT_W-1:0]  n_ld_on_st,
  output logic [CNT_W-1:0]  n_ld_on_ld,
  output logic              err_deadlock,
  output logic              err_orphan
);

  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int TIME_W = $clog2(THRESH) + 2;
  localparam int OCC_W  = $clog2(ENTRIES + 1);

  logic [LINE_W-1:0] req_line, cpl_line;
  logic              unused_offsets;
  logic              req_wr;
  logic              rd_lu_hit, wr_lu_hit, rd_free, wr_free;
  logic              rd_rm_hit, wr_rm_hit, rd_aged, wr_aged;
  logic [OCC_W-1:0]  rd_occ, wr_occ;
  logic              same_hit, cross_hit, tgt_free, is_full;
  req_status_e       status;
  logic              fire, issue, rm_ok;
  logic [CW-1:0]     cnt_q, cnt_nxt;
  logic [TIME_W-1:0] now;
  logic              rdy_q;

  assign req_line       = req_addr[ADDR_W-1:OFF_W];
  assign cpl_line       = cpl_addr[ADDR_W-1:OFF_W];
  assign unused_offsets = ^{req_addr[OFF_W-1:0], cpl_addr[OFF_W-1:0]};
  assign req_wr         = is_write_kind(req_kind);

  // Classification against the state held at the start of the cycle.
  assign same_hit  = req_wr ? wr_lu_hit : rd_lu_hit;
  assign cross_hit = req_wr ? rd_lu_hit : wr_lu_hit;
  assign tgt_free  = req_wr ? wr_free   : rd_free;
  assign is_full   = (cnt_q >= CW'(MAX_OUT)) || !tgt_free;

  always_comb begin
    if (is_full)                    status = ST_FULL;
    else if (same_hit || cross_hit) status = ST_ALIASED;
    else                            status = ST_ISSUED;
  end

  assign req_status = status;
  assign req_ready  = rdy_q;
  assign fire       = req_valid && rdy_q;
  assign issue      = fire && (status == ST_ISSUED);
  assign rm_ok      = cpl_valid && (cpl_write ? wr_rm_hit : rd_rm_hit);
  assign cnt_nxt    = cnt_q + CW'(issue) - CW'(rm_ok);
  assign out_count  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      rdy_q      <= 1'b0;
      err_orphan <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      rdy_q <= 1'b1;
      if (cpl_valid && !rm_ok) err_orphan <= 1'b1;
    end
  end

  ort_line_table #(
    .ENTRIES(ENTRIES), .LINE_W(LINE_W), .TIME_W(TIME_W), .THRESH(THRESH)
  ) u_rd_tbl (
    .clk(clk), .rst(rst),
    .lu_line(req_line), .lu_hit(rd_lu_hit), .has_free(rd_free),
    .ins_en(issue && !req_wr), .now(now),
    .rm_en(cpl_valid && !cpl_write), .rm_line(cpl_line), .rm_hit(rd_rm_hit),
    .aged_any(rd_aged), .occ(rd_occ)
  );

  ort_line_table #(
    .ENTRIES(ENTRIES), .LINE_W(LINE_W), .TIME_W(TIME_W), .THRESH(THRESH)
  ) u_wr_tbl (
    .clk(clk), .rst(rst),
    .lu_line(req_line), .lu_hit(wr_lu_hit), .has_free(wr_free),
    .ins_en(issue && req_wr), .now(now),
    .rm_en(cpl_valid && cpl_write), .rm_line(cpl_line), .rm_hit(wr_rm_hit),
    .aged_any(wr_aged), .occ(wr_occ)
  );

  ort_watchdog #(.THRESH(THRESH), .TIME_W(TIME_W)) u_wdog (
    .clk(clk), .rst(rst),
    .busy_nxt(cnt_nxt != '0),
    .aged_any(rd_aged || wr_aged),
    .now(now), .err(err_deadlock)
  );

  ort_alias_stats #(.CNT_W(CNT_W)) u_stats (
    .clk(clk), .rst(rst),
    .hit_en(fire && (status == ST_ALIASED)),
    .req_wr(req_wr), .cross_hit(cross_hit),
    .n_st_on_ld(n_st_on_ld), .n_st_on_st(n_st_on_st),
    .n_ld_on_st(n_ld_on_st), .n_ld_on_ld(n_ld_on_ld)
  );

endmodule

// File: rtl/ort_tracker_chk.sv
module ort_tracker_chk #(
  parameter int MAX_OUT = 12,
  parameter int CW      = 4,
  parameter int OCC_W   = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic [1:0]       req_status,
  input logic             cpl_valid,
  input logic [CW-1:0]    out_count,
  input logic [OCC_W-1:0] occ_rd,
  input logic [OCC_W-1:0] occ_wr,
  input logic             issue,
  input logic             rm_ok,
  input logic             err_deadlock,
  input logic             err_orphan
);

  a_r10_occ_sum: assert property (@(posedge clk) disable iff (rst)
    int'(out_count) == int'(occ_rd) + int'(occ_wr));

  a_r10_cap: assert property (@(posedge clk) disable iff (rst)
    int'(out_count) <= MAX_OUT);

  a_r3_full_at_cap: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && int'(out_count) >= MAX_OUT) |-> (req_status == 2'd2));

  a_r9_count_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> int'(out_count) ==
             int'($past(out_count)) + int'($past(issue)) - int'($past(rm_ok)));

  a_r5_refused_no_change: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_status != 2'd0 && !rm_ok) |=> $stable(out_count));

  a_r8_orphan_sticky: assert property (@(posedge clk) disable iff (rst)
    err_orphan |=> err_orphan);

  a_r8_orphan_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(err_orphan) |-> $past(cpl_valid));

  a_r11_deadlock_sticky: assert property (@(posedge clk) disable iff (rst)
    err_deadlock |=> err_deadlock);

  a_r12_deadlock_needs_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(err_deadlock) |-> $past(out_count) != '0);

  a_r1_ready_after_reset: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> req_ready);

endmodule

bind ort_tracker ort_tracker_chk #(.MAX_OUT(MAX_OUT), .CW(CW), .OCC_W(OCC_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_status(req_status), .cpl_valid(cpl_valid), .out_count(out_count),
  .occ_rd(rd_occ), .occ_wr(wr_occ), .issue(issue), .rm_ok(rm_ok),
  .err_deadlock(err_deadlock), .err_orphan(err_orphan)
);

// File: tb/sim_ort_tracker.sv
`timescale 1ns/1ps
module sim_ort_tracker;

  localparam int TH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_kind = '0;
  logic [1:0]  req_status;
  logic        cpl_valid = 1'b0;
  logic [31:0] cpl_addr = '0;
  logic        cpl_write = 1'b0;
  logic [3:0]  out_count;
  logic [7:0]  n_sl, n_ss, n_ls, n_ll;
  logic        err_deadlock, err_orphan;

  int nchk = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ort_tracker #(
    .ADDR_W(32), .OFF_W(6), .ENTRIES(8), .MAX_OUT(12), .THRESH(TH), .CNT_W(8)
  ) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_kind(req_kind), .req_status(req_status),
    .cpl_valid(cpl_valid), .cpl_addr(cpl_addr), .cpl_write(cpl_write),
    .out_count(out_count), .n_st_on_ld(n_sl), .n_st_on_st(n_ss),
    .n_ld_on_st(n_ls), .n_ld_on_ld(n_ll),
    .err_deadlock(err_deadlock), .err_orphan(err_orphan)
  );

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ln(input int idx, input int off);
    return (32'(idx) << 6) | 32'(off & 63);
  endfunction

  function automatic bit wr_class(input int k);
    return (k != 0) && (k != 1);
  endfunction

  task automatic do_reset();
    rst = 1'b1; req_valid = 1'b0; cpl_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic send(input logic [31:0] a, input int k, output int st);
    req_valid = 1'b1; req_addr = a; req_kind = 4'(k);
    #1 st = int'(req_status);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic cpl(input logic [31:0] a, input bit w);
    cpl_valid = 1'b1; cpl_addr = a; cpl_write = w;
    @(negedge clk);
    cpl_valid = 1'b0;
  endtask

  task automatic both(input logic [31:0] a, input int k, input logic [31:0] ca,
                      input bit w, output int st);
    cpl_valid = 1'b1; cpl_addr = ca; cpl_write = w;
    req_valid = 1'b1; req_addr = a; req_kind = 4'(k);
    #1 st = int'(req_status);
    @(negedge clk);
    req_valid = 1'b0; cpl_valid = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog: run did not finish actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    int st;
    // R1: reset state
    repeat (2) @(negedge clk);
    check("R1 ready in reset", int'(req_ready), 0);
    check("R1 count in reset", int'(out_count), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ready after reset", int'(req_ready), 1);
    check("R1 flags", int'({err_deadlock, err_orphan}), 0);
    check("R1 counters", int'(n_sl) + int'(n_ss) + int'(n_ls) + int'(n_ll), 0);

    // R2 R4 R6 R7: sweep of resident kind vs new kind
    for (int k1 = 0; k1 < 10; k1++) begin
      for (int k2 = 0; k2 < 16; k2++) begin
        bit w1, w2;
        int e_sl, e_ss, e_ls, e_ll;
        w1 = wr_class(k1); w2 = wr_class(k2);
        e_sl = (w2 && !w1) ? 1 : 0;
        e_ss = (w2 && w1) ? 1 : 0;
        e_ls = (!w2 && w1) ? 1 : 0;
        e_ll = (!w2 && !w1) ? 1 : 0;
        do_reset();
        send(ln(5, 3), k1, st);
        check("R4 first issued", st, 0);
        send(ln(5, k2 * 3), k2, st);
        check("R4 same line aliased", st, 1);
        check("R6 st_on_ld", int'(n_sl), e_sl);
        check("R6 st_on_st", int'(n_ss), e_ss);
        check("R6 ld_on_st", int'(n_ls), e_ls);
        check("R6 ld_on_ld", int'(n_ll), e_ll);
        check("R5 count after alias", int'(out_count), 1);
        send(ln(9, 0), k2, st);
        check("R4 other line issued", st, 0);
        check("R7 count two", int'(out_count), 2);
        cpl(ln(5, 7), w1);
        check("R2 R7 retire resident class", int'(out_count), 1);
        cpl(ln(9, 1), w2);
        check("R2 R7 retire new class", int'(out_count), 0);
        check("R8 no orphan in sweep", int'(err_orphan), 0);
      end
    end

    // R3 R5: table limit, count cap, full priority
    do_reset();
    for (int i = 0; i < 8; i++) begin
      send(ln(i, 0), 2 + i, st);
      check("R3 write fill issued", st, 0);
    end
    check("R10 count 8", int'(out_count), 8);
    send(ln(8, 0), 3, st);
    check("R3 write table full", st, 2);
    check("R5 count after full", int'(out_count), 8);
    send(ln(0, 0), 0, st);
    check("R4 load on store aliased", st, 1);
    check("R6 ld_on_st", int'(n_ls), 1);
    for (int i = 0; i < 4; i++) begin
      send(ln(16 + i, 0), i % 2, st);
      check("R3 read fill issued", st, 0);
    end
    check("R10 count at cap", int'(out_count), 12);
    send(ln(20, 0), 0, st);
    check("R3 cap full", st, 2);
    send(ln(16, 0), 0, st);
    check("R3 full before alias", st, 2);
    check("R6 full not counted", int'(n_ll), 0);
    check("R5 count unchanged", int'(out_count), 12);
    cpl(ln(16, 0), 1'b0);
    check("R7 retire read", int'(out_count), 11);
    send(ln(16, 5), 1, st);
    check("R7 freed line issued", st, 0);
    check("R10 count back at cap", int'(out_count), 12);

    // R8: orphan completions
    do_reset();
    send(ln(2, 0), 2, st);
    cpl(ln(2, 0), 1'b0);
    check("R8 wrong table orphan", int'(err_orphan), 1);
    check("R8 count unchanged", int'(out_count), 1);
    cpl(ln(2, 0), 1'b1);
    check("R8 orphan sticky", int'(err_orphan), 1);
    check("R7 retire write", int'(out_count), 0);

    // R9: request and completion in one cycle
    do_reset();
    send(ln(3, 0), 2, st);
    both(ln(3, 9), 0, ln(3, 0), 1'b1, st);
    check("R9 same line aliased", st, 1);
    check("R9 count after retire", int'(out_count), 0);
    check("R9 ld_on_st", int'(n_ls), 1);
    send(ln(3, 0), 0, st);
    check("R9 reissue", st, 0);
    both(ln(4, 0), 2, ln(3, 0), 1'b0, st);
    check("R9 other line issued", st, 0);
    check("R9 net count", int'(out_count), 1);
    cpl(ln(4, 0), 1'b1);
    check("R9 drained", int'(out_count), 0);
    check("R9 no orphan", int'(err_orphan), 0);

    // R11: lone entry ages out exactly at TH edges
    do_reset();
    send(ln(1, 0), 2, st);
    repeat (TH - 1) @(negedge clk);
    check("R11 before threshold", int'(err_deadlock), 0);
    @(negedge clk);
    check("R11 at threshold", int'(err_deadlock), 1);
    repeat (3) @(negedge clk);
    check("R11 sticky", int'(err_deadlock), 1);

    // R11: younger entry caught at the following check
    do_reset();
    send(ln(1, 0), 2, st);
    repeat (2) @(negedge clk);
    send(ln(2, 0), 0, st);
    repeat (4) @(negedge clk);
    cpl(ln(1, 0), 1'b1);
    repeat (8) @(negedge clk);
    check("R11 young at first check", int'(err_deadlock), 0);
    repeat (15) @(negedge clk);
    check("R11 before second check", int'(err_deadlock), 0);
    @(negedge clk);
    check("R11 second check fires", int'(err_deadlock), 1);

    // R12: retire early, idle, then phase restarts
    do_reset();
    send(ln(1, 0), 0, st);
    repeat (5) @(negedge clk);
    cpl(ln(1, 0), 1'b0);
    repeat (40) @(negedge clk);
    check("R12 retired no error", int'(err_deadlock), 0);
    send(ln(6, 0), 9, st);
    repeat (TH - 1) @(negedge clk);
    check("R12 restart before", int'(err_deadlock), 0);
    @(negedge clk);
    check("R12 restart phase", int'(err_deadlock), 1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule